// File: doc/BRIEF.md
# Cache Line Retirement Controller

This block manages a small set-associative cache whose storage words carry a single-error-correcting, double-error-detecting code. Every read hit is decoded. A single flipped bit is repaired in the returned data, and the repaired word is rewritten into the array. Each line keeps a small saturating tally of the corrections it has needed. When that tally reaches a programmable limit, or when a read finds an error the code cannot repair, the controller empties the line and marks it retired. The cache never fills that line again and never matches on it, and every other line keeps working. No restart is needed.

A retired clean line loses nothing: the next access to its address misses and fetches the word from memory again. A retired dirty line is treated by how it failed. After a repaired error its corrected word is written to memory. After an unrepairable error its word is returned to the requester with a poison flag, and memory is left untouched. If every way of a set has been retired, requests to that set go straight to memory. A fault port can flip any bits of a stored codeword, so the error paths can be exercised. Three saturating status counters report corrections, unrepairable errors and retired lines.

Top module: `cld_line_retire`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_wr_en is 0, all three status counters are 0 and the correction limit is 2.
- R2: When no faults are present, a read (rsp_valid and rsp_rdata one cycle after acceptance) returns the value most recently written to that address, whether it hits, misses and fills, or bypasses. A write produces no response.
- R3: A read hit on a line with exactly one flipped codeword bit (the fault port XORs flt_mask into the stored codeword, and bit 0 is the overall parity bit) returns the corrected data with rsp_poison 0 and raises cnt_ce by one. The counters saturate at all ones.
- R4: When the line's correction tally after the increment is still below the limit, req_ready is low for exactly one cycle after the response while the corrected word is written back. A following read of that line then causes no new correction.
- R5: When the line's 2-bit saturating tally after the increment is at or above the limit (loaded from thr_value when thr_load is 1), the line is retired. In that case req_ready is low for exactly two cycles and cnt_del rises by one.
- R6: A read hit with two flipped bits raises cnt_ue by one and retires the line (req_ready low two cycles, cnt_del plus one).
- R7: An unrepairable error on a clean line returns the word fetched from memory, with rsp_poison 0.
- R8: An unrepairable error on a dirty line returns rsp_poison 1 and writes nothing to memory. The lost write is not recovered, and a later read returns the older memory value.
- R9: Retiring a dirty line after a corrected error writes the corrected word to its memory address, so a later read returns it.
- R10: A retired way is never hit or refilled. When all ways of a set are retired, reads return memory data and writes go to memory.
- R11: A miss whose victim way holds dirty data writes that data to the victim's memory address before the line is reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_load | input | 1 | Load the correction limit |
| thr_value | input | 2 | New correction limit |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low bits select the set |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DATA_W | Read data |
| rsp_poison | output | 1 | Read data is known bad |
| mem_rd_addr | output | ADDR_W | Memory read address (combinational read) |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| flt_en | input | 1 | Apply fault mask this cycle |
| flt_set | input | SET_W | Set to corrupt |
| flt_way | input | WAY_W | Way to corrupt |
| flt_mask | input | CODE_W | Bits of the stored codeword to flip |
| cnt_ce | output | CNT_W | Corrected-error count |
| cnt_ue | output | CNT_W | Unrepairable-error count |
| cnt_del | output | CNT_W | Retired-line count |

## Verification
The correction of a read hit and the decision to retire that line happen in the same accepted cycle. The repaired data must leave on the response while the purge is already chosen in place of the rewrite. This is provoked by planting one-bit faults in a line whose tally is one below the limit: once at the reset limit of 2, and once after the limit is lowered to 1, on both a clean line and a dirty line. The bench judges it from the returned data, from two stalled cycles instead of one, from the counters, and from whether the dirty word later reads back from memory. The unrepairable case pairs the response with retirement in the same way, and the bench checks the poison flag and the absence of any memory write.

// File: rtl/cld_pkg.sv
// Shared types and code functions for the line retirement controller.
// Assumes DATA_W data bits protected by PAR_W Hamming bits plus one
// overall parity bit at codeword bit 0; PAR_W must cover DATA_W+PAR_W+1.
package cld_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int CODE_W = DATA_W + PAR_W + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SCRUB, ST_PURGE, ST_DELETE} rt_state_e;

    typedef struct packed {
        data_t data;
        logic  ce;
        logic  ue;
    } dec_t;

    // True for positions that hold a Hamming check bit
    function automatic logic is_pow2(input int pos);
        return (pos & (pos - 1)) == 0;
    endfunction

    // Build a codeword: data in non-power-of-two slots, checks, then parity
    function automatic code_t ecc_encode(input data_t d);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!is_pow2(pos)) begin
                c[pos] = d[k];
                k++;
            end
        end
        for (int p = 0; p < PAR_W; p++) begin
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (!is_pow2(pos) && pos[p]) c[1 << p] = c[1 << p] ^ c[pos];
            end
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    // Decode: repair one bit, flag two-bit (or out-of-range) patterns
    function automatic dec_t ecc_decode(input code_t c);
        dec_t             r;
        code_t            f;
        logic [PAR_W-1:0] syn;
        int               k;
        syn = '0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (c[pos]) syn = syn ^ pos[PAR_W-1:0];
        end
        f    = c;
        r.ce = 1'b0;
        r.ue = 1'b0;
        if (^c) begin
            if (int'(syn) < CODE_W) begin
                f[syn] = ~f[syn];
                r.ce   = 1'b1;
            end else begin
                r.ue = 1'b1;
            end
        end else if (syn != '0) begin
            r.ue = 1'b1;
        end
        r.data = '0;
        k = 0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!is_pow2(pos)) begin
                r.data[k] = f[pos];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/cld_sat_counter.sv
// Saturating event counter. Counts one per cycle with inc high and
// holds at all ones. Assumes at most one event per cycle.
module cld_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Advance unless already at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (inc && ~&count)    count <= count + 1'b1;
    end
endmodule

// File: rtl/cld_way_select.sv
// Way lookup and victim choice for one set. A hit needs tag match, valid
// and not retired. The victim is the lowest free live way, otherwise the
// lowest live way. Assumes the caller treats all_del as "no victim".
module cld_way_select #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  match_vec,
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAYS-1:0]  del_vec,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             all_del,
    output logic [WAY_W-1:0] vic_way
);
    logic [WAY_W-1:0] live_way;
    logic [WAY_W-1:0] free_way;
    logic             free_any;

    // Priority-encode hit, first live way and first free live way
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        live_way = '0;
        free_way = '0;
        free_any = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w] && valid_vec[w] && !del_vec[w]) begin
                hit     = 1'b1;
                hit_way = w[WAY_W-1:0];
            end
            if (!del_vec[w]) live_way = w[WAY_W-1:0];
            if (!del_vec[w] && !valid_vec[w]) begin
                free_any = 1'b1;
                free_way = w[WAY_W-1:0];
            end
        end
        all_del = &del_vec;
        vic_way = free_any ? free_way : live_way;
    end
endmodule

// File: rtl/cld_retire_fsm.sv
// Sequencer for the post-read actions: one cycle of rewrite after a repair,
// or an invalidate cycle followed by a retire cycle. Requests are taken
// only in idle. Assumes go_purge and go_scrub arrive only from idle.
module cld_retire_fsm
    import cld_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_scrub,
    input  logic      go_purge,
    output rt_state_e state,
    output logic      ready
);
    // Step through the sequence; purge has priority over rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   state <= go_purge ? ST_PURGE : (go_scrub ? ST_SCRUB : ST_IDLE);
                ST_PURGE:  state <= ST_DELETE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Accept requests only when no sequence runs
    always_comb ready = (state == ST_IDLE);
endmodule

// File: rtl/cld_line_retire.sv
// Cache controller that retires lines at run time. Reads are decoded and
// repaired, per-line correction tallies drive retirement, unrepairable
// errors retire at once, and fully retired sets bypass to memory.
// Assumes a memory with combinational read and write on the clock edge.
module cld_line_retire
    import cld_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int CNT_W  = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_load,
    input  logic [1:0]        thr_value,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_poison,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              flt_en,
    input  logic [SET_W-1:0]  flt_set,
    input  logic [WAY_W-1:0]  flt_way,
    input  logic [CODE_W-1:0] flt_mask,
    output logic [CNT_W-1:0]  cnt_ce,
    output logic [CNT_W-1:0]  cnt_ue,
    output logic [CNT_W-1:0]  cnt_del
);
    localparam int N_STAT = 3;

    code_t            arr_code [SETS][WAYS];
    logic [TAG_W-1:0] arr_tag  [SETS][WAYS];
    logic [1:0]       arr_cnt  [SETS][WAYS];
    logic [WAYS-1:0]  arr_vld  [SETS];
    logic [WAYS-1:0]  arr_dty  [SETS];
    logic [WAYS-1:0]  arr_del  [SETS];

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag_in;
    logic [WAYS-1:0]   match_vec;
    logic              hit, all_del, hit_dirty, evict;
    logic [WAY_W-1:0]  hit_way, vic_way;
    dec_t              hit_dec;
    data_t             vic_data;
    logic [1:0]        cur_cnt, cnt_next, thr_q;
    logic              acc, rd_hit, wr_hit, miss, byp, ce_ev, ue_ev;
    logic              go_purge, go_scrub;
    rt_state_e         st;
    logic [SET_W-1:0]  tgt_set;
    logic [WAY_W-1:0]  tgt_way;
    logic [ADDR_W-1:0] tgt_addr;
    data_t             tgt_data;
    logic              tgt_wb;
    logic [N_STAT-1:0] ev_inc;
    logic [CNT_W-1:0]  ev_cnt [N_STAT];

    assign set_idx     = req_addr[SET_W-1:0];
    assign tag_in      = req_addr[ADDR_W-1:SET_W];
    assign mem_rd_addr = req_addr;

    // Tag comparators, one per way
    for (genvar w = 0; w < WAYS; w++) begin : g_match
        assign match_vec[w] = (arr_tag[set_idx][w] == tag_in);
    end

    cld_way_select #(.WAYS(WAYS), .WAY_W(WAY_W)) u_sel (
        .match_vec (match_vec),
        .valid_vec (arr_vld[set_idx]),
        .del_vec   (arr_del[set_idx]),
        .hit       (hit),
        .hit_way   (hit_way),
        .all_del   (all_del),
        .vic_way   (vic_way)
    );

    cld_retire_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_scrub (go_scrub),
        .go_purge (go_purge),
        .state    (st),
        .ready    (req_ready)
    );

    // Classify the accepted request and decode the addressed lines
    always_comb begin
        acc       = req_valid && req_ready;
        hit_dec   = ecc_decode(arr_code[set_idx][hit_way]);
        vic_data  = ecc_decode(arr_code[set_idx][vic_way]).data;
        hit_dirty = arr_dty[set_idx][hit_way];
        cur_cnt   = arr_cnt[set_idx][hit_way];
        cnt_next  = (cur_cnt == 2'b11) ? 2'b11 : cur_cnt + 2'd1;
        rd_hit    = acc && !req_write && hit;
        wr_hit    = acc && req_write && hit;
        miss      = acc && !hit && !all_del;
        byp       = acc && all_del;
        ce_ev     = rd_hit && hit_dec.ce;
        ue_ev     = rd_hit && hit_dec.ue;
        go_purge  = ue_ev || (ce_ev && (cnt_next >= thr_q));
        go_scrub  = ce_ev && !go_purge;
        evict     = miss && arr_vld[set_idx][vic_way] && arr_dty[set_idx][vic_way];
    end

    // Memory write source: purge writeback, bypass write, or dirty eviction
    always_comb begin
        mem_wr_en   = 1'b0;
        mem_wr_addr = req_addr;
        mem_wr_data = req_wdata;
        if (st == ST_PURGE) begin
            mem_wr_en   = tgt_wb;
            mem_wr_addr = tgt_addr;
            mem_wr_data = tgt_data;
        end else if (byp && req_write) begin
            mem_wr_en = 1'b1;
        end else if (evict) begin
            mem_wr_en   = 1'b1;
            mem_wr_addr = {arr_tag[set_idx][vic_way], set_idx};
            mem_wr_data = vic_data;
        end
    end

    // Line state: valid, dirty, retired and correction tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                arr_vld[s] <= '0;
                arr_dty[s] <= '0;
                arr_del[s] <= '0;
                for (int w = 0; w < WAYS; w++) arr_cnt[s][w] <= '0;
            end
        end else begin
            if (miss) begin
                arr_vld[set_idx][vic_way] <= 1'b1;
                arr_dty[set_idx][vic_way] <= req_write;
            end
            if (wr_hit) arr_dty[set_idx][hit_way] <= 1'b1;
            if (ce_ev)  arr_cnt[set_idx][hit_way] <= cnt_next;
            if (st == ST_PURGE) begin
                arr_vld[tgt_set][tgt_way] <= 1'b0;
                arr_dty[tgt_set][tgt_way] <= 1'b0;
            end
            if (st == ST_DELETE) arr_del[tgt_set][tgt_way] <= 1'b1;
        end
    end

    // Codeword and tag storage, with rewrite and fault injection
    always_ff @(posedge clk) begin
        if (miss) begin
            arr_code[set_idx][vic_way] <= ecc_encode(req_write ? req_wdata : mem_rd_data);
            arr_tag[set_idx][vic_way]  <= tag_in;
        end
        if (wr_hit) arr_code[set_idx][hit_way] <= ecc_encode(req_wdata);
        if (st == ST_SCRUB) arr_code[tgt_set][tgt_way] <= ecc_encode(tgt_data);
        if (flt_en) arr_code[flt_set][flt_way] <= arr_code[flt_set][flt_way] ^ flt_mask;
    end

    // Capture the line an error was found on, plus the limit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_set  <= '0;
            tgt_way  <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            tgt_wb   <= 1'b0;
            thr_q    <= 2'd2;
        end else begin
            if (ce_ev || ue_ev) begin
                tgt_set  <= set_idx;
                tgt_way  <= hit_way;
                tgt_addr <= req_addr;
                tgt_data <= hit_dec.data;
                tgt_wb   <= hit_dirty && !hit_dec.ue;
            end
            if (thr_load) thr_q <= thr_value;
        end
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_poison <= 1'b0;
        end else begin
            rsp_valid  <= acc && !req_write;
            rsp_poison <= ue_ev && hit_dirty;
            if (rd_hit && !(hit_dec.ue && !hit_dirty)) rsp_rdata <= hit_dec.data;
            else                                       rsp_rdata <= mem_rd_data;
        end
    end

    // Status counters: corrections, unrepairable errors, retirements
    assign ev_inc = {st == ST_DELETE, ue_ev, ce_ev};
    for (genvar i = 0; i < N_STAT; i++) begin : g_stat
        cld_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev_inc[i]),
            .count (ev_cnt[i])
        );
    end
    assign cnt_ce  = ev_cnt[0];
    assign cnt_ue  = ev_cnt[1];
    assign cnt_del = ev_cnt[2];
endmodule

// File: rtl/cld_line_retire_chk.sv
// Port-level checker for the line retirement controller, bound to the top.
// Assumes reset is held for at least two clock cycles.
module cld_line_retire_chk #(
    parameter int CNT_W = 16,
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_poison,
    input logic [CNT_W-1:0] cnt_ce,
    input logic [CNT_W-1:0] cnt_ue,
    input logic [CNT_W-1:0] cnt_del
);
    logic [2:0] busy_run;

    // Length of the current run of stalled cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= '0;
        else if (req_ready)  busy_run <= '0;
        else if (busy_run != 3'b111) busy_run <= busy_run + 3'd1;
    end

    // R5
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 3'd2);

    // R2
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R8
    poison_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_poison |-> rsp_valid);

    // R3
    ce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ce == $past(cnt_ce)) || (cnt_ce == $past(cnt_ce) + 1'b1));

    // R6
    ue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ue == $past(cnt_ue)) || (cnt_ue == $past(cnt_ue) + 1'b1));

    // R10
    del_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_del <= CNT_W'(LINES));
endmodule

bind cld_line_retire cld_line_retire_chk #(.CNT_W(CNT_W), .LINES(SETS * WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_poison (rsp_poison),
    .cnt_ce     (cnt_ce),
    .cnt_ue     (cnt_ue),
    .cnt_del    (cnt_del)
);

// File: tb/sim_cld_line_retire.sv
module sim_cld_line_retire;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_load = 1'b0;
    logic [1:0]  thr_value = 2'd0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_poison;
    logic [7:0]  rsp_rdata, mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
    logic        mem_wr_en;
    logic        flt_en = 1'b0;
    logic [1:0]  flt_set = '0;
    logic [0:0]  flt_way = '0;
    logic [12:0] flt_mask = '0;
    logic [15:0] cnt_ce, cnt_ue, cnt_del;

    logic [7:0]  mem    [256];
    logic [7:0]  shadow [256];
    int          n_chk = 0, n_fail = 0, wr_seen = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cld_line_retire u0 (.*);

    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // Memory model: combinational read, write on the edge, filled in reset
    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_seen <= wr_seen + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output logic po, output logic rv, output int busy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; po = rsp_poison; rv = rsp_valid;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
    endtask

    task automatic inject(input logic [1:0] s, input logic w, input logic [12:0] m);
        @(negedge clk);
        flt_en = 1'b1; flt_set = s; flt_way = w; flt_mask = m;
        @(negedge clk);
        flt_en = 1'b0;
    endtask

    initial begin
        logic [7:0] rd, d, a;
        logic       po, rv, wr;
        int         bz, w0;
        for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_wr_en", mem_wr_en, 0);
        chk("R1 counters", {cnt_ce, cnt_ue, cnt_del}, 0);

        // R2 fill of 0x10 into set 0 way 0
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R2 fill data", rd, init_val(8'h10));
        chk("R2 rsp_valid", rv, 1);
        // R3/R4 single fault, below the reset limit of 2
        inject(2'd0, 1'b0, 13'h0020);
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R3 corrected", rd, init_val(8'h10));
        chk("R3 poison", po, 0);
        chk("R3 cnt_ce", cnt_ce, 1);
        chk("R4 stall", bz, 1);
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R4 rewritten", cnt_ce, 1);
        // R5 second fault reaches limit 2, clean line retired
        inject(2'd0, 1'b0, 13'h0004);
        w0 = wr_seen;
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R5 corrected", rd, init_val(8'h10));
        chk("R5 stall", bz, 2);
        chk("R5 cnt_del", cnt_del, 1);
        chk("R5 clean no write", wr_seen - w0, 0);
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R10 refetch other way", rd, init_val(8'h10));
        // R8 dirty line with two flips in way 1
        op(1, 8'h10, 8'h5A, rd, po, rv, bz);
        chk("R2 write no rsp", rv, 0);
        inject(2'd0, 1'b1, 13'h0088);
        w0 = wr_seen;
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R8 poison", po, 1);
        chk("R6 cnt_ue", cnt_ue, 1);
        chk("R6 stall", bz, 2);
        chk("R6 cnt_del", cnt_del, 2);
        chk("R8 no write", wr_seen - w0, 0);
        // R10 set 0 now fully retired: bypass
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R10 bypass read", rd, init_val(8'h10));
        op(1, 8'h10, 8'h33, rd, po, rv, bz);
        shadow[8'h10] = 8'h33;
        op(0, 8'h10, 0, rd, po, rv, bz);
        chk("R10 bypass write", rd, 8'h33);
        chk("R10 no counts", {cnt_ce, cnt_ue}, {16'd2, 16'd1});
        // R7 clean line, two flips
        op(0, 8'h21, 0, rd, po, rv, bz);
        inject(2'd1, 1'b0, 13'h0088);
        op(0, 8'h21, 0, rd, po, rv, bz);
        chk("R7 refetched", rd, init_val(8'h21));
        chk("R7 poison", po, 0);
        chk("R6 cnt_ue", cnt_ue, 2);
        chk("R6 cnt_del", cnt_del, 3);
        // R5 limit lowered to 1: first fault retires
        @(negedge clk); thr_load = 1'b1; thr_value = 2'd1;
        @(negedge clk); thr_load = 1'b0;
        op(0, 8'h42, 0, rd, po, rv, bz);
        inject(2'd2, 1'b0, 13'h0200);
        op(0, 8'h42, 0, rd, po, rv, bz);
        chk("R5 limit1 data", rd, init_val(8'h42));
        chk("R5 limit1 stall", bz, 2);
        chk("R5 limit1 cnt_del", cnt_del, 4);
        // R9 dirty line retired after a correction (parity bit 0 flipped)
        op(1, 8'h83, 8'hC7, rd, po, rv, bz);
        shadow[8'h83] = 8'hC7;
        inject(2'd3, 1'b0, 13'h0001);
        w0 = wr_seen;
        op(0, 8'h83, 0, rd, po, rv, bz);
        chk("R3 parity-bit fault", rd, 8'hC7);
        chk("R9 writeback", wr_seen - w0, 1);
        op(0, 8'h83, 0, rd, po, rv, bz);
        chk("R9 read back", rd, 8'hC7);
        chk("R9 counts", {cnt_ce, cnt_del}, {16'd4, 16'd5});
        // R11 dirty victims in the single live way of set 3
        op(1, 8'h83, 8'h11, rd, po, rv, bz);
        w0 = wr_seen;
        op(1, 8'h87, 8'h22, rd, po, rv, bz);
        chk("R11 evict write", wr_seen - w0, 1);
        op(0, 8'h83, 0, rd, po, rv, bz);
        chk("R11 evicted data", rd, 8'h11);
        op(0, 8'h87, 0, rd, po, rv, bz);
        chk("R11 second victim", rd, 8'h22);
        shadow[8'h83] = 8'h11; shadow[8'h87] = 8'h22;

        // R2/R10 random mix over all sets, including the bypassed set 0
        a = 8'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            a  = 8'($urandom % 256);
            wr = ($urandom % 3) == 0;
            d  = 8'($urandom);
            op(wr, a, d, rd, po, rv, bz);
            if (wr) shadow[a] = d;
            else begin
                chk("R2 random read", rd, shadow[a]);
                chk("R2 random poison", po, 0);
            end
        end
        chk("R3 no stray counts", {cnt_ce, cnt_ue, cnt_del}, {16'd4, 16'd2, 16'd5});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule